// File: doc/BRIEF.md
# Fan Tachometer with Divisor Control

This block measures the rotation period of three fans. Each fan's tach signal is synchronised to the reference clock and its rising edges are detected. Between two rising edges a per-channel counter advances once every 2^s reference cycles, where s is a power-of-two shift chosen by a divisor register. On every rising edge the count is latched as the channel's result and the counter restarts from zero. Host software reads the results through a small byte-wide register port and turns them into fan speed.

Each channel is a three-state machine. `CH_WAIT` is the state after reset: no edge has been seen, nothing is counted and the result reads zero. Transition *first-edge* (a rising edge in `CH_WAIT`) enters `CH_COUNT`. In `CH_COUNT`, transition *measure* (a rising edge) latches the count and stays in `CH_COUNT`, and transition *saturate* (the counter reaches its all-ones limit before an edge) forces the result to all-ones and enters `CH_STALL`. In `CH_STALL` the all-ones result is held. Transition *resume* (a rising edge) latches all-ones, restarts the counter and returns to `CH_COUNT`.

By default a count is 8 bits wide and its limit is 0xFF. A per-fan enable bit extends the count to 16 bits, with limit 0xFFFF, and makes the upper byte readable. An all-ones result marks a stopped or too-slow fan. A zero result is a valid reading: the period was shorter than one divisor step.

Top module: `fan_tach_monitor`

## Requirements
- R1: The low count bytes of fans 1, 2 and 3 read at addresses 0, 1 and 2. Reads are combinational from `rd_addr`. Writes to addresses 0, 1, 2, 5, 6 and 7 change no readable value.
- R2: A rising tach edge first sampled at clock edge k shows up in the read result right after clock edge k+2, and not earlier.
- R3: If P clock cycles pass between consecutive rising edges and the channel's shift is s, the latched result is min(floor((P-1)/2^s), limit). The counter restarts at each edge.
- R4: The divisor register at address 3 resets to 0x00. Bits [2:0] give fan 1's shift and bits [5:3] give fan 2's shift. Bit 6 gives fan 3 a shift of 3 when set and 1 when clear. Bit 7 always reads 0.
- R5: The extension enable register at address 4 resets to 0x00. Bit i (i = 0..2) selects 16-bit counting for fan i+1. Bits [7:3] always read 0.
- R6: Addresses 5, 6 and 7 read bits [15:8] of the results of fans 1, 2 and 3 when the fan's enable bit is set. They read 0 when it is clear.
- R7: In 8-bit mode the limit is 0xFF. If the counter reaches it before the next edge, the result becomes 0xFF at once and is held until an edge. A period that is too long also latches 0xFF.
- R8: In 16-bit mode the limit is 0xFFFF, with the same saturate-and-hold behaviour.
- R9: A period shorter than one divisor step gives a result of 0.
- R10: From reset until the second rising edge on a channel, its result reads 0. The first edge only starts counting.
- R11: After reset all eight registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 3 | Tach signals, bit i for fan i+1, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |

## Verification
The assertions are checked on every cycle. They check four things:
- an edge pulse never lasts two cycles;
- a result changes only after an edge pulse or to all-ones;
- a channel in `CH_STALL` always holds an all-ones low byte, and one in `CH_WAIT` always holds zero;
- the unused bits of the divisor and enable registers always read zero.

The exact value of a measured count cannot be seen from single-cycle relations: the (P-1)/2^s arithmetic, the two-cycle synchroniser latency and the packing of the three divisor fields. Saturation after thousands of idle cycles, the masking of upper bytes in 8-bit mode and the ignored writes to count registers are also shown only by the bench's directed scenarios.

// File: rtl/fan_tach_pkg.sv
`timescale 1ns/1ps
package fan_tach_pkg;
    localparam int FAN_NUM        = 3;
    localparam int CNT_W          = 16;
    localparam int BYTE_W         = 8;
    localparam int SHIFT_W        = 3;
    localparam int PRE_W          = (1 << SHIFT_W) - 1;
    localparam int DIV_W          = (FAN_NUM - 1) * SHIFT_W + 1;
    localparam int ADDR_W         = 3;
    localparam int ADDR_CNT_BASE  = 0;
    localparam int ADDR_DIV       = ADDR_CNT_BASE + FAN_NUM;
    localparam int ADDR_EXT       = ADDR_DIV + 1;
    localparam int ADDR_HI_BASE   = ADDR_EXT + 1;
    localparam int LAST_SHIFT_SET = 3;
    localparam int LAST_SHIFT_CLR = 1;

    typedef enum logic [1:0] {
        CH_WAIT  = 2'd0,
        CH_COUNT = 2'd1,
        CH_STALL = 2'd2
    } ch_state_t;
endpackage

// File: rtl/fan_tach_sync.sv
`timescale 1ns/1ps
module fan_tach_sync import fan_tach_pkg::*; #(
    parameter int WIDTH = FAN_NUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] tach_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Two flops against metastability, a third for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= tach_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/fan_tach_channel.sv
`timescale 1ns/1ps
module fan_tach_channel import fan_tach_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               wide,
    output logic [CNT_W-1:0]   result,
    output logic [1:0]         state_o
);
    ch_state_t          state;
    ch_state_t          state_nxt;
    logic [PRE_W-1:0]   presc_q;
    logic [PRE_W-1:0]   step_mask;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   limit;
    logic [CNT_W:0]     cnt_inc;
    logic               tick;
    logic               sat_now;

    assign limit     = wide ? {CNT_W{1'b1}} : CNT_W'({BYTE_W{1'b1}});
    assign step_mask = ~({PRE_W{1'b1}} << shift);
    assign tick      = (presc_q >= step_mask);
    assign cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign sat_now   = (cnt_q >= limit) || (tick && (cnt_inc >= {1'b0, limit}));
    assign state_o   = state;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: first-edge, measure, saturate, resume
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_WAIT: begin
                if (rise) state_nxt = CH_COUNT;
            end
            CH_COUNT: begin
                if (rise)         state_nxt = CH_COUNT;
                else if (sat_now) state_nxt = CH_STALL;
            end
            CH_STALL: begin
                if (rise) state_nxt = CH_COUNT;
            end
            default: state_nxt = CH_WAIT;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
            result  <= '0;
        end else begin
            unique case (state)
                CH_WAIT: begin
                    if (rise) begin
                        presc_q <= '0;
                        cnt_q   <= '0;
                    end
                end
                CH_COUNT: begin
                    if (rise) begin
                        result  <= (cnt_q > limit) ? limit : cnt_q;
                        presc_q <= '0;
                        cnt_q   <= '0;
                    end else if (sat_now) begin
                        result  <= limit;
                        cnt_q   <= limit;
                        presc_q <= '0;
                    end else if (tick) begin
                        presc_q <= '0;
                        cnt_q   <= cnt_q + CNT_W'(1);
                    end else begin
                        presc_q <= presc_q + PRE_W'(1);
                    end
                end
                CH_STALL: begin
                    result <= limit;
                    if (rise) begin
                        presc_q <= '0;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    presc_q <= '0;
                    cnt_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fan_tach_regs.sv
`timescale 1ns/1ps
module fan_tach_regs import fan_tach_pkg::*; (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [BYTE_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [FAN_NUM-1:0][CNT_W-1:0]    results,
    output logic [FAN_NUM-1:0][SHIFT_W-1:0]  shifts,
    output logic [FAN_NUM-1:0]               wide,
    output logic [BYTE_W-1:0]                rd_data
);
    logic [DIV_W-1:0]                 div_q;
    logic [FAN_NUM-1:0]               ext_q;
    logic [FAN_NUM-1:0][BYTE_W-1:0]   lo_view;
    logic [FAN_NUM-1:0][BYTE_W-1:0]   hi_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ext_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_DIV)) div_q <= wr_data[DIV_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_EXT)) ext_q <= wr_data[FAN_NUM-1:0];
        end
    end

    assign wide = ext_q;

    for (genvar g = 0; g < FAN_NUM; g++) begin : g_fan
        if (g < FAN_NUM - 1) begin : g_field
            assign shifts[g] = div_q[g*SHIFT_W +: SHIFT_W];
        end else begin : g_bit
            assign shifts[g] = div_q[DIV_W-1] ? SHIFT_W'(LAST_SHIFT_SET)
                                              : SHIFT_W'(LAST_SHIFT_CLR);
        end
        // In 8-bit mode an out-of-range leftover reads as saturated.
        assign lo_view[g] = (!ext_q[g] && (results[g][CNT_W-1:BYTE_W] != '0))
                            ? {BYTE_W{1'b1}} : results[g][BYTE_W-1:0];
        assign hi_view[g] = ext_q[g] ? results[g][CNT_W-1:BYTE_W] : '0;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_DIV)) rd_data = BYTE_W'(div_q);
        if (rd_addr == ADDR_W'(ADDR_EXT)) rd_data = BYTE_W'(ext_q);
        for (int i = 0; i < FAN_NUM; i++) begin
            if (rd_addr == ADDR_W'(ADDR_CNT_BASE + i)) rd_data = lo_view[i];
            if (rd_addr == ADDR_W'(ADDR_HI_BASE + i))  rd_data = hi_view[i];
        end
    end
endmodule

// File: rtl/fan_tach_monitor.sv
`timescale 1ns/1ps
module fan_tach_monitor import fan_tach_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FAN_NUM-1:0]  tach_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data
);
    logic [FAN_NUM-1:0]              tach_rise;
    logic [FAN_NUM-1:0][CNT_W-1:0]   fan_result;
    logic [FAN_NUM-1:0][SHIFT_W-1:0] fan_shift;
    logic [FAN_NUM-1:0]              fan_wide;
    logic [FAN_NUM-1:0][1:0]         fan_state;

    fan_tach_sync #(.WIDTH(FAN_NUM)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tach_in (tach_in),
        .rise    (tach_rise)
    );

    for (genvar g = 0; g < FAN_NUM; g++) begin : g_ch
        fan_tach_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (tach_rise[g]),
            .shift   (fan_shift[g]),
            .wide    (fan_wide[g]),
            .result  (fan_result[g]),
            .state_o (fan_state[g])
        );
    end

    fan_tach_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .results (fan_result),
        .shifts  (fan_shift),
        .wide    (fan_wide),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/fan_tach_monitor_chk.sv
`timescale 1ns/1ps
module fan_tach_monitor_chk import fan_tach_pkg::*; (
    input logic                            clk,
    input logic                            rst_n,
    input logic [FAN_NUM-1:0]              rise,
    input logic [FAN_NUM-1:0][CNT_W-1:0]   res,
    input logic [FAN_NUM-1:0][1:0]         st,
    input logic [ADDR_W-1:0]               rd_addr,
    input logic [BYTE_W-1:0]               rd_data
);
    for (genvar g = 0; g < FAN_NUM; g++) begin : g_chk
        assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);

        assert_result_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(res[g]) |-> ($past(rise[g]) || (res[g][BYTE_W-1:0] == {BYTE_W{1'b1}})));

        assert_stall_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == CH_STALL) |-> (res[g][BYTE_W-1:0] == {BYTE_W{1'b1}}));

        assert_wait_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == CH_WAIT) |-> (res[g] == '0));
    end

    assert_div_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADDR_DIV)) |-> (rd_data[BYTE_W-1:DIV_W] == '0));

    assert_ext_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADDR_EXT)) |-> (rd_data[BYTE_W-1:FAN_NUM] == '0));
endmodule

bind fan_tach_monitor fan_tach_monitor_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (tach_rise),
    .res     (fan_result),
    .st      (fan_state),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/test_fan_tach_monitor.sv
`timescale 1ns/1ps
module test_fan_tach_monitor;
    import fan_tach_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tach_in;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    logic tach_q [3] = '{1'b0, 1'b0, 1'b0};
    int   per [3]    = '{0, 0, 0};
    bit   man [3]    = '{1'b0, 1'b0, 1'b0};
    int   n_checks = 0;
    int   n_fail   = 0;

    always #2.5 clk = ~clk;
    assign tach_in = {tach_q[2], tach_q[1], tach_q[0]};

    fan_tach_monitor i_fan_tach_monitor (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic run_tach(input int idx);
        forever begin
            if (man[idx] || per[idx] == 0) begin
                if (!man[idx]) tach_q[idx] = 1'b0;
                @(negedge clk);
            end else begin
                int p = per[idx];
                tach_q[idx] = 1'b1;
                repeat (p / 2) @(negedge clk);
                tach_q[idx] = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    endtask

    initial run_tach(0);
    initial run_tach(1);
    initial run_tach(2);

    function automatic int exp_count(input int p, input int s, input bit wide16);
        int lim = wide16 ? 65535 : 255;
        int v = (p - 1) >> s;
        return (v > lim) ? lim : v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = a[2:0];
        #1;
        d = int'(rd_data);
    endtask

    task automatic chk_reg(input string req, input string what, input int a, input int exp);
        int d;
        @(negedge clk);
        rd(a, d);
        check(req, what, d, exp);
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int p);
        repeat (3 * p + 1100) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) chk_reg("R11", "reset value", a, 0);
        repeat (300) @(negedge clk);
        for (int a = 0; a < 3; a++) chk_reg("R10", "no edge yet", a, 0);
    endtask

    task automatic t_timing();
        int d;
        man[0] = 1'b1;
        @(negedge clk);
        tach_q[0] = 1'b1;
        repeat (5) @(negedge clk);
        tach_q[0] = 1'b0;
        rd(0, d);
        check("R10", "after first edge", d, 0);
        repeat (15) @(negedge clk);
        tach_q[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(0, d);
        check("R2", "one cycle early", d, 0);
        @(negedge clk);
        rd(0, d);
        check("R2", "latched at k+2", d, exp_count(20, 0, 1'b0));
        tach_q[0] = 1'b0;
        man[0] = 1'b0;
    endtask

    task automatic t_divisors();
        wr(ADDR_DIV, 8'h6F);
        chk_reg("R4", "divisor readback", ADDR_DIV, 8'h6F);
        per[0] = 300; per[1] = 200; per[2] = 100;
        settle(300);
        chk_reg("R3", "fan1 shift7", 0, exp_count(300, 7, 1'b0));
        chk_reg("R4", "fan2 shift5", 1, exp_count(200, 5, 1'b0));
        chk_reg("R4", "fan3 bit set", 2, exp_count(100, 3, 1'b0));
        wr(ADDR_DIV, 8'hFF);
        chk_reg("R4", "bit7 reads 0", ADDR_DIV, 8'h7F);
        wr(ADDR_DIV, 8'h00);
        per[0] = 100; per[1] = 100; per[2] = 100;
        settle(100);
        chk_reg("R3", "fan1 shift0", 0, exp_count(100, 0, 1'b0));
        chk_reg("R3", "fan2 shift0", 1, exp_count(100, 0, 1'b0));
        chk_reg("R4", "fan3 bit clear", 2, exp_count(100, 1, 1'b0));
    endtask

    task automatic t_zero();
        wr(ADDR_DIV, 8'h08);
        per[1] = 2;
        settle(2);
        chk_reg("R9", "short period", 1, 0);
        chk_reg("R4", "fan1 field untouched", 0, exp_count(100, 0, 1'b0));
    endtask

    task automatic t_stall8();
        per[2] = 0;
        repeat (300) @(negedge clk);
        chk_reg("R7", "held before saturation", 2, exp_count(100, 1, 1'b0));
        repeat (400) @(negedge clk);
        chk_reg("R7", "stall without edge", 2, 255);
        per[0] = 1000;
        settle(1000);
        chk_reg("R7", "long period clamps", 0, exp_count(1000, 0, 1'b0));
        chk_reg("R6", "upper byte in 8-bit mode", ADDR_HI_BASE, 0);
    endtask

    task automatic t_ext();
        int v;
        wr(ADDR_EXT, 8'hFF);
        chk_reg("R5", "enable readback", ADDR_EXT, 8'h07);
        wr(ADDR_DIV, 8'h00);
        per[0] = 1000; per[1] = 600; per[2] = 1000;
        settle(1000);
        v = exp_count(1000, 0, 1'b1);
        chk_reg("R6", "fan1 low", 0, v & 255);
        chk_reg("R6", "fan1 high", ADDR_HI_BASE, v >> 8);
        v = exp_count(600, 0, 1'b1);
        chk_reg("R6", "fan2 low", 1, v & 255);
        chk_reg("R6", "fan2 high", ADDR_HI_BASE + 1, v >> 8);
        v = exp_count(1000, 1, 1'b1);
        chk_reg("R6", "fan3 low", 2, v & 255);
        chk_reg("R6", "fan3 high", ADDR_HI_BASE + 2, v >> 8);
    endtask

    task automatic t_wr_ignore();
        int v = exp_count(600, 0, 1'b1);
        wr(0, 8'h00);
        wr(1, 8'h00);
        wr(ADDR_HI_BASE + 1, 8'hAA);
        chk_reg("R1", "fan2 low after write", 1, v & 255);
        chk_reg("R1", "fan2 high after write", ADDR_HI_BASE + 1, v >> 8);
        chk_reg("R1", "fan1 low after write", 0, exp_count(1000, 0, 1'b1) & 255);
    endtask

    task automatic t_stall16();
        per[0] = 0;
        repeat (65536 + 1200) @(negedge clk);
        chk_reg("R8", "16-bit stall low", 0, 255);
        chk_reg("R8", "16-bit stall high", ADDR_HI_BASE, 255);
        wr(ADDR_EXT, 8'h06);
        chk_reg("R6", "high masked after disable", ADDR_HI_BASE, 0);
        chk_reg("R7", "low stays saturated", 0, 255);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_divisors();
        t_zero();
        t_stall8();
        t_ext();
        t_wr_ignore();
        t_stall16();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule